// File: doc/BRIEF.md
# Alternating-Compare PWM Timer Channel

A 16-bit timer channel that builds a pulse-width-modulated waveform from two compare registers. One compare register sets how long the output stays low and the other sets how long it stays high. The channel switches between them every time the active one matches. Each compare register has a preload companion. The low-phase compare is refreshed from its preload when the high phase ends, and the high-phase compare is refreshed when the low phase ends. Software can therefore change the duty cycle at any moment, and the running phase is never cut short.

The channel is driven by a single register-write port, a count-enable tick that comes from a prescaled clock, and the system clock. A three-state machine runs the channel. `PH_HALT` is the stopped state. `PH_LOW` counts the low phase against the low compare. `PH_HIGH` counts the high phase against the high compare. These transitions exist: `start` (HALT to LOW, or to HIGH when the low compare is 0 and the high compare is not), `swap` (LOW to HIGH and back on a match whose next-phase length is nonzero), `stay` (a match whose next-phase length is 0 keeps the phase and restarts it), and `stop` (any running state to HALT when run is cleared or force is set). In reinitialise mode the counter counts each phase up from 0, or down from the phase length to 0. In free-running mode it wraps through the full range and sets an overflow flag when it wraps. The pin can be inverted or disabled. Four sticky flags feed one interrupt line through per-flag enables.

Top module: `altcmp_pwm_timer`

## Requirements
- R1: After reset the pin is 0, the counter is 0, all flags are 0 and the interrupt is 0.
- R2: With run=ctrl bit 0 and reinit=ctrl bit 2 set and counting up, the low phase lasts exactly cmp_lo ticks and the high phase exactly cmp_hi ticks. The counter returns to 0 on the same edge at which the pin toggles.
- R3: A low-phase match copies pre_hi into cmp_hi, and a high-phase match copies pre_lo into cmp_lo. A preload written in the middle of a period changes only the phases that begin after the next such copy.
- R4: With down=ctrl bit 1 set in reinit mode, the counter is loaded with the phase length, counts down, and matches when it reaches 0. The phase lengths are the same as when counting up.
- R5: With reinit clear, the counter is never cleared on a match. A match occurs when the next count equals the active compare. A wrap (0xFFFF to 0 up, 0 to 0xFFFF down) sets the overflow flag (bit 3).
- R6: A compare value of 0 disables its phase. The match that would enter that phase keeps the current one instead, so the pin stays constant with no glitch.
- R7: The pin equals out_en AND (level XOR invert), where invert=ctrl bit 3, out_en=ctrl bit 5, and level is 1 only in PH_HIGH.
- R8: force=ctrl bit 4 halts the channel, holds the counter at 0 and the level at 0. With out_en clear the pin is 0.
- R9: Flags are any-match (bit 0), low-match (bit 1), high-match (bit 2) and overflow (bit 3). Hardware sets them. Writing the flag register clears each bit written as 0 and keeps each bit written as 1, and a hardware set wins over a clear.
- R10: irq is 1 exactly when some flag bit and its enable bit are both 1.
- R11: The counter changes only on cycles where tick is 1 while the channel runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 ctrl, 1 cmp_lo, 2 cmp_hi, 3 pre_lo, 4 pre_hi, 5 flags, 6 irq enables |
| wr_data | input | 16 | Write data |
| tick | input | 1 | Count enable from the prescaler |
| pwm_out | output | 1 | PWM pin |
| cnt_out | output | 16 | Current counter value |
| flags_out | output | 4 | Sticky match and overflow flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures high and low run lengths before and after a preload change made mid-period. A design that reloaded the wrong register, or reloaded at the wrong match, would give phase lengths one period early or swapped. Zero-length phases are held for many cycles to catch a one-cycle glitch pulse that a naive toggle would emit. Down counting, inversion, tick gating, write-0-to-clear flags and a full 65536-tick free-running wrap are each compared every clock against a behavioural model. An off-by-one in the match test or the wrap detection would show up as a counter or flag mismatch.

// File: rtl/altcmp_pkg.sv
package altcmp_pkg;
    localparam int ADDR_W = 3;
    localparam int FLAG_N = 4;
    localparam int CTRL_N = 6;

    localparam int F_ANY = 0;
    localparam int F_LO  = 1;
    localparam int F_HI  = 2;
    localparam int F_OVF = 3;

    localparam int C_RUN    = 0;
    localparam int C_DOWN   = 1;
    localparam int C_REINIT = 2;
    localparam int C_INV    = 3;
    localparam int C_FORCE  = 4;
    localparam int C_OE     = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_CMP_LO = 3'd1,
        A_CMP_HI = 3'd2,
        A_PRE_LO = 3'd3,
        A_PRE_HI = 3'd4,
        A_FLAGS  = 3'd5,
        A_IEN    = 3'd6
    } reg_addr_t;

    typedef enum logic [1:0] {
        PH_HALT = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;
endpackage

// File: rtl/altcmp_cfg_regs.sv
module altcmp_cfg_regs
    import altcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic                  ld_lo,
    input  logic                  ld_hi,
    input  logic [FLAG_N-1:0]     flag_set,
    output logic [CTRL_N-1:0]     ctrl_q,
    output logic [CNT_W-1:0]      cmp_lo,
    output logic [CNT_W-1:0]      cmp_hi,
    output logic [CNT_W-1:0]      pre_lo,
    output logic [CNT_W-1:0]      pre_hi,
    output logic [FLAG_N-1:0]     flags,
    output logic [FLAG_N-1:0]     ien
);
    logic sel_ctrl, sel_clo, sel_chi, sel_plo, sel_phi, sel_flg, sel_ien;

    always_comb begin
        sel_ctrl = wr_en && (wr_addr == A_CTRL);
        sel_clo  = wr_en && (wr_addr == A_CMP_LO);
        sel_chi  = wr_en && (wr_addr == A_CMP_HI);
        sel_plo  = wr_en && (wr_addr == A_PRE_LO);
        sel_phi  = wr_en && (wr_addr == A_PRE_HI);
        sel_flg  = wr_en && (wr_addr == A_FLAGS);
        sel_ien  = wr_en && (wr_addr == A_IEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pre_lo <= '0;
            pre_hi <= '0;
            ien    <= '0;
        end else begin
            if (sel_ctrl) ctrl_q <= wr_data[CTRL_N-1:0];
            if (sel_plo)  pre_lo <= wr_data;
            if (sel_phi)  pre_hi <= wr_data;
            if (sel_ien)  ien    <= wr_data[FLAG_N-1:0];
        end
    end

    // Hardware reload from the preload has priority over a software write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_lo <= '0;
            cmp_hi <= '0;
        end else begin
            if (ld_lo)        cmp_lo <= pre_lo;
            else if (sel_clo) cmp_lo <= wr_data;
            if (ld_hi)        cmp_hi <= pre_hi;
            else if (sel_chi) cmp_hi <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            for (int b = 0; b < FLAG_N; b++) begin
                if (flag_set[b])                  flags[b] <= 1'b1;
                else if (sel_flg && !wr_data[b])  flags[b] <= 1'b0;
            end
        end
    end

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flg && !wr_data[F_LO] && !flag_set[F_LO]) |=> !flags[F_LO]);
endmodule

// File: rtl/altcmp_phase_engine.sv
module altcmp_phase_engine
    import altcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              down,
    input  logic              reinit,
    input  logic              force_hold,
    input  logic [CNT_W-1:0]  cmp_lo,
    input  logic [CNT_W-1:0]  cmp_hi,
    input  logic [CNT_W-1:0]  pre_lo,
    input  logic [CNT_W-1:0]  pre_hi,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              level,
    output logic              ld_lo,
    output logic              ld_hi,
    output logic [FLAG_N-1:0] flag_set
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    phase_t           st;
    logic [CNT_W-1:0] act, nxt, other, start_len;
    phase_t           start_ph;
    logic             halt_req, adv, hit, wrap, swap;

    always_comb begin
        halt_req  = !run || force_hold;
        adv       = (st != PH_HALT) && !halt_req && tick;
        act       = (st == PH_HIGH) ? cmp_hi : cmp_lo;
        other     = (st == PH_HIGH) ? pre_lo : pre_hi;
        nxt       = down ? (cnt_q - CNT_ONE) : (cnt_q + CNT_ONE);
        start_ph  = ((cmp_lo != '0) || (cmp_hi == '0)) ? PH_LOW : PH_HIGH;
        start_len = (start_ph == PH_LOW) ? cmp_lo : cmp_hi;
        hit       = 1'b0;
        wrap      = 1'b0;
        if (adv) begin
            if (reinit && down) hit = (act != '0) && (nxt == '0);
            else                hit = (act != '0) && (nxt == act);
            wrap = !reinit && (down ? (cnt_q == '0) : (cnt_q == CNT_MAX));
        end
        swap            = hit && (other != '0);
        ld_hi           = hit && (st == PH_LOW);
        ld_lo           = hit && (st == PH_HIGH);
        flag_set[F_ANY] = hit;
        flag_set[F_LO]  = ld_hi;
        flag_set[F_HI]  = ld_lo;
        flag_set[F_OVF] = wrap;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= PH_HALT;
        end else begin
            unique case (st)
                PH_HALT: if (!halt_req) st <= start_ph;
                PH_LOW:  if (halt_req) st <= PH_HALT;
                         else if (swap) st <= PH_HIGH;
                PH_HIGH: if (halt_req) st <= PH_HALT;
                         else if (swap) st <= PH_LOW;
                default: st <= PH_HALT;
            endcase
        end
    end

    // Counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (halt_req) begin
            cnt_q <= '0;
        end else if (st == PH_HALT) begin
            cnt_q <= (down && reinit) ? start_len : '0;
        end else if (adv) begin
            if (hit && reinit) cnt_q <= down ? (swap ? other : act) : '0;
            else               cnt_q <= nxt;
        end
    end

    // Output level from the state register only
    always_comb level = (st == PH_HIGH);

    // R8
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_hold |=> (cnt_q == '0 && !level));
    // R11
    no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PH_HALT && !halt_req && !tick) |=> $stable(cnt_q));
    // R2
    reinit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && reinit && !down) |=> (cnt_q == '0));
    // R4
    down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && reinit && down) |=> (cnt_q != '0));
    // R3
    reload_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hi |=> (cmp_hi == $past(pre_hi)));
endmodule

// File: rtl/altcmp_pwm_timer.sv
module altcmp_pwm_timer
    import altcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              tick,
    output logic              pwm_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [3:0]        flags_out,
    output logic              irq
);
    logic [CTRL_N-1:0] ctrl_q;
    logic [CNT_W-1:0]  cmp_lo, cmp_hi, pre_lo, pre_hi;
    logic [FLAG_N-1:0] flags, ien, flag_set;
    logic              ld_lo, ld_hi, level;

    altcmp_cfg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ld_lo(ld_lo), .ld_hi(ld_hi), .flag_set(flag_set),
        .ctrl_q(ctrl_q), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
        .pre_lo(pre_lo), .pre_hi(pre_hi), .flags(flags), .ien(ien)
    );

    altcmp_phase_engine #(.CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .run(ctrl_q[C_RUN]), .down(ctrl_q[C_DOWN]), .reinit(ctrl_q[C_REINIT]),
        .force_hold(ctrl_q[C_FORCE]),
        .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .pre_lo(pre_lo), .pre_hi(pre_hi),
        .cnt_q(cnt_out), .level(level), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .flag_set(flag_set)
    );

    always_comb begin
        pwm_out   = ctrl_q[C_OE] & (level ^ ctrl_q[C_INV]);
        flags_out = flags;
        irq       = |(flags & ien);
    end
endmodule

// File: tb/altcmp_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module altcmp_pwm_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tick = 1'b0;
    logic        pwm_out;
    logic [15:0] cnt_out;
    logic [3:0]  flags_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    altcmp_pwm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .pwm_out(pwm_out), .cnt_out(cnt_out),
        .flags_out(flags_out), .irq(irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_ph, m_cnt, m_ca, m_cb, m_pa, m_pb, m_ctrl, m_fl, m_ien;
    always @(posedge clk) begin : model
        int run, dn, ri, frc, act, oth, n, hit, wrap, sw, set, ph_n, cnt_n, ca_n, cb_n, st;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_ca = 0; m_cb = 0; m_pa = 0; m_pb = 0;
            m_ctrl = 0; m_fl = 0; m_ien = 0;
        end else begin
            run = m_ctrl & 1; dn = (m_ctrl >> 1) & 1; ri = (m_ctrl >> 2) & 1;
            frc = (m_ctrl >> 4) & 1;
            hit = 0; wrap = 0; set = 0; ph_n = m_ph; cnt_n = m_cnt;
            ca_n = m_ca; cb_n = m_cb;
            if (run == 0 || frc == 1) begin
                ph_n = 0; cnt_n = 0;
            end else if (m_ph == 0) begin
                st = (m_ca != 0 || m_cb == 0) ? 1 : 2;
                ph_n = st;
                cnt_n = (dn == 1 && ri == 1) ? ((st == 1) ? m_ca : m_cb) : 0;
            end else if (tick) begin
                act = (m_ph == 1) ? m_ca : m_cb;
                oth = (m_ph == 1) ? m_pb : m_pa;
                n = dn ? (m_cnt + 65535) % 65536 : (m_cnt + 1) % 65536;
                if (ri == 1 && dn == 1) hit = (act != 0 && n == 0);
                else                    hit = (act != 0 && n == act);
                wrap = (ri == 0) && (dn ? (m_cnt == 0) : (m_cnt == 65535));
                cnt_n = n;
                if (hit) begin
                    sw = (oth != 0);
                    set = set | 1 | ((m_ph == 1) ? 2 : 4);
                    if (m_ph == 1) cb_n = m_pb; else ca_n = m_pa;
                    if (sw) ph_n = 3 - m_ph;
                    if (ri == 1) cnt_n = dn ? (sw ? oth : act) : 0;
                end
                if (wrap) set = set | 8;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_ctrl = wr_data & 63;
                    3'd1: if (!(hit && m_ph == 2)) ca_n = wr_data;
                    3'd2: if (!(hit && m_ph == 1)) cb_n = wr_data;
                    3'd3: m_pa = wr_data;
                    3'd4: m_pb = wr_data;
                    3'd5: m_fl = m_fl & wr_data & 15;
                    3'd6: m_ien = wr_data & 15;
                    default: ;
                endcase
            end
            m_fl = m_fl | set;
            m_ph = ph_n; m_cnt = cnt_n; m_ca = ca_n; m_cb = cb_n;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        int lvl, epwm;
        if (rst_n && !done) begin
            lvl = (m_ph == 2) ? 1 : 0;
            epwm = ((m_ctrl >> 5) & 1) & (lvl ^ ((m_ctrl >> 3) & 1));
            check("R7", "pwm_out", int'(pwm_out), epwm);
            check("R2", "cnt_out", int'(cnt_out), m_cnt);
            check("R9", "flags_out", int'(flags_out), m_fl);
            check("R10", "irq", int'(irq), ((m_fl & m_ien) != 0) ? 1 : 0);
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(output int hi, output int lo);
        while (pwm_out !== 1'b0) @(negedge clk);
        while (pwm_out !== 1'b1) @(negedge clk);
        hi = 0;
        while (pwm_out === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (pwm_out === 1'b0) begin lo++; @(negedge clk); end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin : stim
        int hi, lo, cnt_hold, seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "pwm at reset", int'(pwm_out), 0);
        check("R1", "cnt at reset", int'(cnt_out), 0);
        check("R1", "flags at reset", int'(flags_out), 0);
        check("R1", "irq at reset", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 basic up-count reinit phases
        wr(1, 3); wr(2, 5); wr(3, 3); wr(4, 5); wr(6, 6);
        tick = 1'b1;
        wr(0, 'h25);
        measure(hi, lo);
        measure(hi, lo);
        check("R2", "high phase length", hi, 5);
        check("R2", "low phase length", lo, 3);
        check("R10", "irq with match enables", int'(irq), 1);

        // R3 preload update mid-period
        repeat (2) @(negedge clk);
        wr(3, 6); wr(4, 2);
        measure(hi, lo); measure(hi, lo); measure(hi, lo);
        check("R3", "high after preload", hi, 2);
        check("R3", "low after preload", lo, 6);

        // R7 inversion
        wr(0, 'h2D);
        measure(hi, lo); measure(hi, lo);
        check("R7", "inverted high length", hi, 6);
        check("R7", "inverted low length", lo, 2);

        // R4 down counting
        wr(0, 'h27);
        measure(hi, lo); measure(hi, lo);
        check("R4", "down high length", hi, 2);
        check("R4", "down low length", lo, 6);
        while (pwm_out !== 1'b0) @(negedge clk);
        while (pwm_out !== 1'b1) @(negedge clk);
        check("R4", "count loaded at high entry", int'(cnt_out), 2);

        // R6 zero-length phases
        wr(0, 'h25);
        wr(4, 0);
        repeat (40) @(negedge clk);
        seen = 0;
        for (int i = 0; i < 50; i++) begin seen += int'(pwm_out); @(negedge clk); end
        check("R6", "high samples with cmp_hi=0", seen, 0);
        wr(4, 4); wr(3, 0);
        repeat (40) @(negedge clk);
        seen = 0;
        for (int i = 0; i < 50; i++) begin seen += (pwm_out ? 0 : 1); @(negedge clk); end
        check("R6", "low samples with cmp_lo=0", seen, 0);

        // R9 / R10 flag clearing
        wr(0, 'h20);
        wr(5, 'h5);
        check("R9", "partial clear keeps 1-bits", int'(flags_out), 5);
        wr(5, 0);
        check("R9", "flags cleared", int'(flags_out), 0);
        check("R10", "irq after clear", int'(irq), 0);

        // R11 tick gating
        wr(1, 3); wr(2, 5); wr(3, 3); wr(4, 5);
        wr(0, 'h25);
        for (int i = 0; i < 40; i++) begin tick = (i % 3 == 0); @(negedge clk); end
        tick = 1'b0;
        @(negedge clk);
        cnt_hold = int'(cnt_out);
        @(negedge clk);
        check("R11", "count without tick", int'(cnt_out), cnt_hold);
        tick = 1'b1;

        // R5 free-running wrap and overflow
        wr(0, 'h20);
        wr(1, 100); wr(2, 200); wr(3, 100); wr(4, 200); wr(6, 8);
        wr(0, 'h21);
        repeat (65600) @(negedge clk);
        check("R5", "overflow flag", int'(flags_out[3]), 1);
        check("R10", "irq from overflow", int'(irq), 1);

        // R8 force and output disable
        wr(0, 'h35);
        repeat (2) @(negedge clk);
        check("R8", "count under force", int'(cnt_out), 0);
        check("R8", "pin under force", int'(pwm_out), 0);
        wr(1, 3); wr(2, 5); wr(3, 3); wr(4, 5);
        wr(0, 'h05);
        seen = 0;
        for (int i = 0; i < 20; i++) begin seen += int'(pwm_out); @(negedge clk); end
        check("R8", "pin with output disabled", seen, 0);

        finish_run();
    end
endmodule